// File: doc/BRIEF.md
# Privilege-Based Peripheral Access Checker

This block stands between the bus arbiter and the peripheral bus and decides, for each transaction aimed at peripheral space, whether it may reach its target. The privilege of a transaction is not carried by the transaction. It is looked up from a per-master level register, in which each master is either supervisor or user. Each peripheral region has its own access field, and a user-level master is checked against the field of the region it addresses. Supervisor-level masters reach every region.

A request is presented for one cycle with `req_valid`. In the next cycle the block does one of two things. If the access is allowed, it raises the target select together with a registered copy of the address and direction. If the access is refused, it raises a one-cycle error and leaves the target select low, so the peripheral never sees the access.

Configuration is written through two strobed inputs, one for the master level vector and one for the region access vector. A write becomes effective for requests made in the cycle after the strobe. After reset every master is supervisor and every region is closed to user access.

Top module: `priv_access_check`

## Requirements
- R1: After reset, `tgt_sel` and `req_err` are low. Every master is supervisor. Every region field is 0, meaning user read and user write are both refused.
- R2: The region of a request is the top `RIDX_W` bits of `req_addr`, which is bits 15..12 with the defaults. The remaining address bits do not affect the decision.
- R3: A request from a master whose level bit is 0 (supervisor) is always granted, for reads and writes in every region.
- R4: A user read (`req_write`=0) is granted exactly when bit 0 of the addressed region's field is 1.
- R5: A user write (`req_write`=1) is granted exactly when bit 1 of the addressed region's field is 1.
- R6: A granted request drives `tgt_sel` high for exactly the following cycle. In that cycle `tgt_addr` and `tgt_write` equal the request's address and direction, and `req_err` is low.
- R7: A refused request drives `req_err` high for exactly the following cycle, and `tgt_sel` stays low.
- R8: A cycle without `req_valid` is followed by a cycle in which both `tgt_sel` and `req_err` are low.
- R9: `mpriv_we` loads `mpriv_wdata`. Bit m set to 1 makes master m a user, and bit m at 0 makes it supervisor. A request in the same cycle as the write is still judged by the old levels.
- R10: `racc_we` loads `racc_wdata`, and the field of region r sits at bits [2r+1:2r]. A request in the same cycle as the write is still judged by the old fields.
- R11: `tgt_sel` and `req_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mpriv_we | input | 1 | Load the master level vector |
| mpriv_wdata | input | N_MASTERS | New master levels, 1 = user |
| racc_we | input | 1 | Load the region access vector |
| racc_wdata | input | 2*N_REGIONS | New region fields, 2 bits per region |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | MID_W | Issuing master |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Target address in peripheral space |
| tgt_sel | output | 1 | Registered target select for granted requests |
| tgt_write | output | 1 | Registered direction |
| tgt_addr | output | ADDR_W | Registered address |
| req_err | output | 1 | One-cycle error for refused requests |

## Verification
The assertions check, on every cycle, that each request is answered in the next cycle by exactly one of select or error. They also check that idle cycles produce neither, that the two outputs never coincide, that supervisor requests are always selected, and that the level register holds its value without a write strobe. What the assertions cannot see is whether the answer is correct for a given region field and direction. Only the bench scenarios show that, along with the exact bit position of each field, the address bits that choose the region, and the old-value behaviour when a configuration write and a request share a cycle.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic {
    LVL_SUPER = 1'b0,
    LVL_USER  = 1'b1
  } priv_e;

  // bit 1: user write allowed, bit 0: user read allowed
  typedef struct packed {
    logic wr_ok;
    logic rd_ok;
  } racc_t;
endpackage

// File: rtl/pac_master_levels.sv
module pac_master_levels
  import pac_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int MID_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [N_MASTERS-1:0] wdata,
  input  logic [MID_W-1:0]     sel,
  output priv_e                lvl
);
  logic [N_MASTERS-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst)     lvl_q <= '0;
    else if (we) lvl_q <= wdata;
  end

  always_comb begin
    lvl = LVL_SUPER;
    if (int'(sel) < N_MASTERS && lvl_q[sel]) lvl = LVL_USER;
  end

  // R9
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(lvl_q));
endmodule

// File: rtl/pac_region_table.sv
module pac_region_table
  import pac_pkg::*;
#(
  parameter int N_REGIONS = 16,
  parameter int RIDX_W    = $clog2(N_REGIONS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [2*N_REGIONS-1:0] wdata,
  input  logic [RIDX_W-1:0]      sel,
  output racc_t                  acc
);
  racc_t fld_q [N_REGIONS];

  for (genvar r = 0; r < N_REGIONS; r++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst)     fld_q[r] <= '0;
      else if (we) fld_q[r] <= racc_t'(wdata[2*r +: 2]);
    end
  end

  assign acc = fld_q[sel];
endmodule

// File: rtl/pac_decide.sv
module pac_decide
  import pac_pkg::*;
(
  input  priv_e lvl,
  input  racc_t acc,
  input  logic  is_write,
  output logic  allow
);
  always_comb begin
    if (lvl == LVL_SUPER) allow = 1'b1;
    else if (is_write)    allow = acc.wr_ok;
    else                  allow = acc.rd_ok;
  end
endmodule

// File: rtl/priv_access_check.sv
module priv_access_check
  import pac_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int MID_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  parameter int N_REGIONS = 16,
  parameter int ADDR_W    = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mpriv_we,
  input  logic [N_MASTERS-1:0]   mpriv_wdata,
  input  logic                   racc_we,
  input  logic [2*N_REGIONS-1:0] racc_wdata,
  input  logic                   req_valid,
  input  logic [MID_W-1:0]       req_master,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   tgt_sel,
  output logic                   tgt_write,
  output logic [ADDR_W-1:0]      tgt_addr,
  output logic                   req_err
);
  localparam int RIDX_W = $clog2(N_REGIONS);

  logic [RIDX_W-1:0] region;
  priv_e             lvl;
  racc_t             acc;
  logic              allow;

  assign region = req_addr[ADDR_W-1 -: RIDX_W];

  pac_master_levels #(.N_MASTERS(N_MASTERS), .MID_W(MID_W)) u_lvl (
    .clk(clk), .rst(rst), .we(mpriv_we), .wdata(mpriv_wdata),
    .sel(req_master), .lvl(lvl)
  );

  pac_region_table #(.N_REGIONS(N_REGIONS), .RIDX_W(RIDX_W)) u_tbl (
    .clk(clk), .rst(rst), .we(racc_we), .wdata(racc_wdata),
    .sel(region), .acc(acc)
  );

  pac_decide u_dec (
    .lvl(lvl), .acc(acc), .is_write(req_write), .allow(allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_sel   <= 1'b0;
      req_err   <= 1'b0;
      tgt_write <= 1'b0;
      tgt_addr  <= '0;
    end else begin
      tgt_sel <= req_valid && allow;
      req_err <= req_valid && !allow;
      if (req_valid && allow) begin
        tgt_write <= req_write;
        tgt_addr  <= req_addr;
      end
    end
  end

  // R11
  no_dual_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tgt_sel, req_err}));

  // R6 R7
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (tgt_sel ^ req_err));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!tgt_sel && !req_err));

  // R3
  super_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lvl == LVL_SUPER) |=> tgt_sel);
endmodule

// File: tb/sim_priv_access_check.sv
`timescale 1ns/1ps
module sim_priv_access_check;
  localparam int NM = 4;
  localparam int NR = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mpriv_we = 1'b0;
  logic [NM-1:0] mpriv_wdata = '0;
  logic          racc_we = 1'b0;
  logic [2*NR-1:0] racc_wdata = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_master = '0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          tgt_sel, tgt_write, req_err;
  logic [AW-1:0] tgt_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  priv_access_check u0 (
    .clk(clk), .rst(rst),
    .mpriv_we(mpriv_we), .mpriv_wdata(mpriv_wdata),
    .racc_we(racc_we), .racc_wdata(racc_wdata),
    .req_valid(req_valid), .req_master(req_master),
    .req_write(req_write), .req_addr(req_addr),
    .tgt_sel(tgt_sel), .tgt_write(tgt_write),
    .tgt_addr(tgt_addr), .req_err(req_err)
  );

  // reference state
  logic [NM-1:0]   m_lvl = '0;
  logic [2*NR-1:0] m_acc = '0;

  // expectation for the cycle after the last step
  logic          e_sel = 0, e_err = 0, e_wr = 0;
  logic [AW-1:0] e_addr = '0;
  string         e_tag = "R8";

  function automatic logic ref_allow(int m, logic w, logic [AW-1:0] a);
    int r;
    r = int'(a[AW-1 -: 4]);
    if (!m_lvl[m]) return 1'b1;
    return w ? m_acc[2*r+1] : m_acc[2*r];
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic verify();
    chk({tgt_sel, req_err} == {e_sel, e_err}, e_tag, "sel/err",
        int'({tgt_sel, req_err}), int'({e_sel, e_err}));
    if (e_sel)
      chk({tgt_write, tgt_addr} == {e_wr, e_addr}, "R6", "wr/addr",
          int'({tgt_write, tgt_addr}), int'({e_wr, e_addr}));
  endtask

  task automatic step(logic v, int m, logic w, logic [AW-1:0] a,
                      logic mwe, logic [NM-1:0] md,
                      logic rwe, logic [2*NR-1:0] rd, string tag);
    logic al;
    @(negedge clk);
    verify();
    req_valid = v; req_master = 2'(m); req_write = w; req_addr = a;
    mpriv_we = mwe; mpriv_wdata = md; racc_we = rwe; racc_wdata = rd;
    al = ref_allow(m, w, a);
    e_sel = v && al;
    e_err = v && !al;
    e_wr = w;
    e_addr = a;
    if (tag != "") e_tag = tag;
    else if (!v) e_tag = "R8";
    else if (!m_lvl[m]) e_tag = "R3";
    else if (w) e_tag = "R5";
    else e_tag = "R4";
    if (mwe) m_lvl = md;
    if (rwe) m_acc = rd;
  endtask

  task automatic req(int m, logic w, logic [AW-1:0] a, string tag);
    step(1'b1, m, w, a, 1'b0, '0, 1'b0, '0, tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 outputs idle after reset
    chk(!tgt_sel && !req_err, "R1", "reset outputs", int'({tgt_sel, req_err}), 0);
    // R1 all masters supervisor at reset
    req(3, 1'b1, 16'h7123, "R1");
    // R9 make master 2 user; a request in the same cycle keeps the old level
    step(1'b1, 2, 1'b0, 16'h1000, 1'b1, 4'b0100, 1'b0, '0, "R9");
    // R1 regions closed to user at reset
    req(2, 1'b0, 16'h1000, "R1");
    req(2, 1'b1, 16'hF000, "R1");
    // R10 open region 5 read only, region 9 write only; same-cycle request sees old
    step(1'b1, 2, 1'b0, 16'h5000, 1'b0, '0, 1'b1,
         (32'b01 << 10) | (32'b10 << 18), "R10");
    req(2, 1'b0, 16'h5ABC, "R10");
    req(2, 1'b1, 16'h5ABC, "R5");
    req(2, 1'b1, 16'h9001, "R10");
    req(2, 1'b0, 16'h9001, "R4");
    // R2 low address bits do not move the region
    req(2, 1'b0, 16'h4FFF, "R2");
    req(2, 1'b0, 16'h5FFF, "R2");
    req(2, 1'b0, 16'h6000, "R2");
    // R3 supervisor master ignores closed regions
    req(0, 1'b1, 16'h4000, "R3");
    // R8 idle
    step(1'b0, 0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R8");
    // R7 back-to-back refusal then grant
    req(2, 1'b1, 16'h0000, "R7");
    req(1, 1'b1, 16'h0000, "R6");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = int'($urandom_range(0, 19));
      step(k != 0, int'($urandom_range(0, 3)), 1'($urandom), 16'($urandom),
           k == 1, 4'($urandom), k == 2, $urandom, "");
    end
    step(1'b0, 0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "");
    @(negedge clk);
    verify();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule